// File: doc/BRIEF.md
# Stalled-Rotor Guard with Timed Auto-Restart

This block watches one Hall phase of a brushless motor and decides whether the motor is actually turning. An internal level counter climbs by a fixed step on every timebase tick. Every transition of the Hall signal, rising or falling, knocks the level down by a larger fixed amount. A motor that turns fast enough keeps the level pinned near its floor. When transitions become too sparse, the level reaches its ceiling and the guard declares a stall.

After a stall, the guard does not latch the drive off. The drive stays off while the level drains back to the floor, at one fourteenth of the climb rate. The drive is then allowed on again while the level climbs back to the ceiling. This long-off/short-on pattern repeats until a Hall transition shows that the rotor moves again. The status flag is high for as long as the guard considers the rotor stuck.

A stop request clears the level to the floor and drops both the drive and the flag. When the guard is disabled, the drive stays permitted and the flag stays low. With default parameters the on burst is 240 ticks and the off gap is 3360 ticks. A Hall period longer than 16 ticks between transitions is treated as too slow.

Top module: `stall_guard`

## Requirements
- R1: After reset, with protection enabled and no stop, `drive_en_o` is 1, `rd_o` is 0 and the level sits at the floor `LO_LVL`.
- R2: The level rises by `CHARGE_STEP` only in cycles where `tick_i` is 1. Starting from the floor with no Hall transitions and a tick every cycle, the stall is declared on the (ON_TICKS+1)-th clock edge, where ON_TICKS = (HI_LVL-LO_LVL)/CHARGE_STEP. With `tick_i` held at 0, no stall is ever declared.
- R3: `fg_i` passes through a two-flop synchronizer. Each transition of either polarity then lowers the level by `BLEED_STEP`, saturating at the floor. A transition cancels the tick step of the same cycle. Transitions spaced fewer than BLEED_STEP/CHARGE_STEP ticks apart never let a stall be declared.
- R4: When the level sits at the ceiling `HI_LVL` and no transition is pending, the guard enters the off phase: `drive_en_o` = 0 and `rd_o` = 1.
- R5: In the off phase the level falls by `CHARGE_STEP` once every `SLOW_RATIO` ticks. With a tick every cycle, `drive_en_o` stays 0 for OFF_TICKS+1 cycles, where OFF_TICKS = ON_TICKS*SLOW_RATIO, and then the on phase begins.
- R6: In the on phase `drive_en_o` = 1 and `rd_o` stays 1 while the level climbs. With a tick every cycle and no transitions, the on phase lasts ON_TICKS+1 cycles and is followed by another off phase.
- R7: A Hall transition in either stall phase releases the guard. `rd_o` falls to 0 and `drive_en_o` rises to 1 on the third clock edge after `fg_i` changes, and not before.
- R8: While `prot_en_i` is 0 and `stop_i` is 0, `drive_en_o` = 1 and `rd_o` = 0, and the level is held at the floor. After re-enabling, a full ON_TICKS+1 ticks pass before a stall is declared.
- R9: While `stop_i` is 1, `drive_en_o` = 0 and `rd_o` = 0, and the level is cleared to the floor. After release, a full ON_TICKS+1 ticks pass before a stall is declared.
- R10: The level never leaves the range from `LO_LVL` to `HI_LVL`, whatever the pattern of ticks and transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe; one level step per tick |
| fg_i | input | 1 | Asynchronous Hall phase signal |
| prot_en_i | input | 1 | 1 enables stall protection |
| stop_i | input | 1 | 1 stops the motor and clears the guard |
| drive_en_o | output | 1 | 1 permits the power stage to drive |
| rd_o | output | 1 | 1 while the rotor is judged stalled |

## Verification
A wrong level value does not show up at once. It shows up as a stall declared too early or too late, so the bench measures trip, off and on durations to the exact cycle against the tick counts derived from the thresholds. A wrong phase register is visible immediately on the two outputs. Release latency through the synchronizer is checked on both sides of the third clock edge. Hall patterns just below and well above the critical transition rate separate a guard that counts both polarities from one that counts only rising edges.

// File: rtl/sg_pkg.sv
package sg_pkg;

    typedef enum logic [1:0] {
        PH_RUN = 2'd0,
        PH_OFF = 2'd1,
        PH_ON  = 2'd2
    } sg_phase_e;

    typedef struct packed {
        logic clear;
        logic bleed;
        logic drain;
        logic charge;
    } sg_cmd_t;

    function automatic int unsigned sg_sat_add(int unsigned v, int unsigned s,
                                               int unsigned ceil_v);
        return (v + s >= ceil_v) ? ceil_v : v + s;
    endfunction

    function automatic int unsigned sg_sat_sub(int unsigned v, int unsigned s,
                                               int unsigned floor_v);
        return (v < floor_v + s) ? floor_v : v - s;
    endfunction

endpackage

// File: rtl/sg_fg_edge.sv
module sg_fg_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fg_i,
    output logic edge_o
);
    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its delayed copy
    logic [SYNC_STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], fg_i};
    end

    assign edge_o = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/sg_drain_pace.sv
module sg_drain_pace #(
    parameter int unsigned SLOW_RATIO = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic tick_i,
    output logic step_o
);
    generate
        if (SLOW_RATIO <= 1) begin : g_direct
            assign step_o = active_i & tick_i;
        end else begin : g_div
            localparam int unsigned PW = $clog2(SLOW_RATIO);
            localparam logic [PW-1:0] LAST = PW'(SLOW_RATIO - 1);
            logic [PW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || !active_i) cnt_q <= '0;
                else if (tick_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            assign step_o = active_i & tick_i & (cnt_q == LAST);

            a_r5_pace_range: assert property (@(posedge clk) disable iff (rst)
                cnt_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/sg_level.sv
module sg_level
    import sg_pkg::*;
#(
    parameter int unsigned LEVEL_W     = 12,
    parameter int unsigned LO_LVL      = 64,
    parameter int unsigned HI_LVL      = 1024,
    parameter int unsigned CHARGE_STEP = 4,
    parameter int unsigned BLEED_STEP  = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  sg_cmd_t cmd_i,
    output logic    at_hi_o,
    output logic    at_lo_o
);
    localparam logic [LEVEL_W-1:0] LO_V = LEVEL_W'(LO_LVL);
    localparam logic [LEVEL_W-1:0] HI_V = LEVEL_W'(HI_LVL);

    logic [LEVEL_W-1:0] level_q, level_d;

    always_comb begin
        level_d = level_q;
        if (cmd_i.clear)
            level_d = LO_V;
        else if (cmd_i.bleed)
            level_d = LEVEL_W'(sg_sat_sub(32'(level_q), BLEED_STEP, LO_LVL));
        else if (cmd_i.drain)
            level_d = LEVEL_W'(sg_sat_sub(32'(level_q), CHARGE_STEP, LO_LVL));
        else if (cmd_i.charge)
            level_d = LEVEL_W'(sg_sat_add(32'(level_q), CHARGE_STEP, HI_LVL));
    end

    always_ff @(posedge clk) begin
        if (rst) level_q <= LO_V;
        else     level_q <= level_d;
    end

    assign at_hi_o = (level_q == HI_V);
    assign at_lo_o = (level_q == LO_V);

    a_r10_level_bounds: assert property (@(posedge clk) disable iff (rst)
        (level_q >= LO_V) && (level_q <= HI_V));

    a_r9_clear_to_floor: assert property (@(posedge clk) disable iff (rst)
        cmd_i.clear |=> (level_q == LO_V));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.clear && !cmd_i.bleed && !cmd_i.drain && !cmd_i.charge)
        |=> $stable(level_q));

    a_r3_bleed_lowers: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.clear && cmd_i.bleed)
        |=> ((level_q < $past(level_q)) || (level_q == LO_V)));

endmodule

// File: rtl/sg_phase_fsm.sv
module sg_phase_fsm
    import sg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear_i,
    input  logic      edge_i,
    input  logic      at_hi_i,
    input  logic      at_lo_i,
    output sg_phase_e phase_o
);
    sg_phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        if (clear_i) begin
            phase_d = PH_RUN;
        end else begin
            unique case (phase_q)
                PH_RUN: if (at_hi_i && !edge_i) phase_d = PH_OFF;
                PH_OFF: if (edge_i)             phase_d = PH_RUN;
                        else if (at_lo_i)       phase_d = PH_ON;
                PH_ON:  if (edge_i)             phase_d = PH_RUN;
                        else if (at_hi_i)       phase_d = PH_OFF;
                default:                        phase_d = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_RUN;
        else     phase_q <= phase_d;
    end

    assign phase_o = phase_q;

    a_r4_off_needs_ceiling: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_OFF && $past(phase_q) != PH_OFF) |-> $past(at_hi_i));

    a_r5_on_needs_floor: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ON && $past(phase_q) != PH_ON) |-> $past(at_lo_i));

    a_r7_edge_releases: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && edge_i && phase_q != PH_RUN) |=> (phase_q == PH_RUN));

endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import sg_pkg::*;
#(
    parameter int unsigned LEVEL_W     = 12,
    parameter int unsigned LO_LVL      = 64,
    parameter int unsigned HI_LVL      = 1024,
    parameter int unsigned CHARGE_STEP = 4,
    parameter int unsigned BLEED_STEP  = 64,
    parameter int unsigned SLOW_RATIO  = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic fg_i,
    input  logic prot_en_i,
    input  logic stop_i,
    output logic drive_en_o,
    output logic rd_o
);
    localparam int unsigned ON_TICKS  = (HI_LVL - LO_LVL) / CHARGE_STEP;
    localparam int unsigned OFF_TICKS = ON_TICKS * SLOW_RATIO;
    localparam int unsigned WIN_W     = $clog2(OFF_TICKS + 2) + 1;

    logic      fg_edge, at_hi, at_lo, drain_step, clear;
    sg_phase_e phase;
    sg_cmd_t   cmd;

    assign clear = stop_i | ~prot_en_i;

    sg_fg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .fg_i   (fg_i),
        .edge_o (fg_edge)
    );

    sg_drain_pace #(.SLOW_RATIO(SLOW_RATIO)) u_pace (
        .clk      (clk),
        .rst      (rst),
        .active_i ((phase == PH_OFF) && !clear),
        .tick_i   (tick_i),
        .step_o   (drain_step)
    );

    always_comb begin
        cmd.clear  = clear;
        cmd.bleed  = fg_edge;
        cmd.drain  = drain_step;
        cmd.charge = tick_i && (phase != PH_OFF);
    end

    sg_level #(
        .LEVEL_W    (LEVEL_W),
        .LO_LVL     (LO_LVL),
        .HI_LVL     (HI_LVL),
        .CHARGE_STEP(CHARGE_STEP),
        .BLEED_STEP (BLEED_STEP)
    ) u_level (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .at_hi_o (at_hi),
        .at_lo_o (at_lo)
    );

    sg_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .edge_i  (fg_edge),
        .at_hi_i (at_hi),
        .at_lo_i (at_lo),
        .phase_o (phase)
    );

    always_comb begin
        if (stop_i)          drive_en_o = 1'b0;
        else if (!prot_en_i) drive_en_o = 1'b1;
        else                 drive_en_o = (phase != PH_OFF);
    end

    assign rd_o = prot_en_i && !stop_i && (phase != PH_RUN);

    // phase-window tick counters, used only by the window checks below
    logic [WIN_W-1:0] on_ticks_q, off_ticks_q;

    always_ff @(posedge clk) begin
        if (rst || phase != PH_ON) on_ticks_q <= '0;
        else if (tick_i)           on_ticks_q <= on_ticks_q + 1'b1;
        if (rst || phase != PH_OFF) off_ticks_q <= '0;
        else if (tick_i)            off_ticks_q <= off_ticks_q + 1'b1;
    end

    a_r6_on_window: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ON) |-> (on_ticks_q <= WIN_W'(ON_TICKS)));

    a_r5_off_window: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OFF) |-> (off_ticks_q <= WIN_W'(OFF_TICKS)));

    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (phase == PH_RUN));

endmodule

// File: tb/tb_stall_guard.sv
module tb_stall_guard;

    localparam int LO    = 64;
    localparam int HI    = 1024;
    localparam int STEP  = 4;
    localparam int BLEED = 64;
    localparam int RATIO = 14;
    localparam int ON_T  = (HI - LO) / STEP;
    localparam int OFF_T = ON_T * RATIO;

    localparam int VEC_N = 5;
    localparam int VEC_P[VEC_N]    = '{4, 8, 15, 30, 60};
    localparam bit VEC_TRIP[VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int VEC_WIN = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic fg = 1'b0;
    logic en = 1'b1;
    logic stop = 1'b0;
    logic drive_en, rd;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    stall_guard #(
        .LEVEL_W(12), .LO_LVL(LO), .HI_LVL(HI), .CHARGE_STEP(STEP),
        .BLEED_STEP(BLEED), .SLOW_RATIO(RATIO), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .fg_i(fg),
        .prot_en_i(en), .stop_i(stop), .drive_en_o(drive_en), .rd_o(rd)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int viol;
        bit seen;

        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 drive after reset", drive_en, 1);
        chk("R1 rd after reset", rd, 0);

        // R2 no tick, no climb
        seen = 0;
        for (int c = 0; c < 300; c++) begin cyc(1); seen |= rd; end
        chk("R2 no trip without ticks", seen, 0);

        // R2/R4 trip timing from the floor
        tick = 1'b1;
        cyc(ON_T);
        chk("R2 rd before trip edge", rd, 0);
        cyc(1);
        chk("R4 rd at trip", rd, 1);
        chk("R4 drive off at trip", drive_en, 0);

        // R5 off length, R6 on length
        n = 0;
        while (!drive_en) begin n++; cyc(1); end
        chk("R5 off phase length", n, OFF_T + 1);
        chk("R6 rd high in on phase", rd, 1);
        n = 0;
        while (drive_en) begin n++; cyc(1); end
        chk("R6 on phase length", n, ON_T + 1);

        // R7 release during on phase
        while (!drive_en) cyc(1);
        cyc(5);
        fg = ~fg;
        cyc(2);
        chk("R7 rd still high before 3rd edge", rd, 1);
        cyc(1);
        chk("R7 rd released in on phase", rd, 0);
        chk("R7 drive after release", drive_en, 1);

        // R7 release during off phase
        while (!rd) cyc(1);
        chk("R4 drive off after retrip", drive_en, 0);
        fg = ~fg;
        cyc(3);
        chk("R7 rd released in off phase", rd, 0);
        chk("R7 drive restored from off phase", drive_en, 1);

        // R9 stop
        stop = 1'b1;
        cyc(1);
        chk("R9 rd low when stopped", rd, 0);
        chk("R9 drive low when stopped", drive_en, 0);
        cyc(10);
        stop = 1'b0;
        cyc(ON_T - 2);
        chk("R9 level cleared, no early trip", rd, 0);
        cyc(5);
        chk("R9 trips after full climb", rd, 1);

        // R8 disable
        en = 1'b0;
        viol = 0;
        for (int c = 0; c < 2000; c++) begin
            cyc(1);
            if (rd || !drive_en) viol++;
        end
        chk("R8 disabled outputs", viol, 0);
        en = 1'b1;
        cyc(ON_T - 2);
        chk("R8 level held at floor", rd, 0);
        cyc(5);
        chk("R8 trips after re-enable", rd, 1);

        // R3 vector table of Hall periods (each toggle is one transition)
        for (int v = 0; v < VEC_N; v++) begin
            stop = 1'b1;
            cyc(2);
            stop = 1'b0;
            seen = 0;
            for (int c = 0; c < VEC_WIN; c++) begin
                if ((c % VEC_P[v]) == VEC_P[v] - 1) fg = ~fg;
                cyc(1);
                seen |= rd;
            end
            chk($sformatf("R3 period %0d trip", VEC_P[v]), seen, VEC_TRIP[v]);
        end

        // R10/R3 floor saturation under a burst of transitions
        stop = 1'b1;
        cyc(2);
        stop = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (c % 2 == 1) fg = ~fg;
            cyc(1);
        end
        cyc(230);
        chk("R10 floor held after burst", rd, 0);
        cyc(25);
        chk("R10 trip after burst", rd, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule